// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM of 32K bytes that shares one data bus for both directions. The host raises a request with a read/write flag, a 15-bit address and, for writes, a data byte. It keeps the request high until it sees a single-cycle acknowledge. For a read, the fetched byte is on the host read-data port in the acknowledge cycle.

On the memory side the controller drives active-low chip enable, write enable and output enable, the address, and a data bus made of an output value and a drive enable. Every strobe is a register output. Each phase length is a parameter counted in clock cycles. A write is framed by write enable, and the address and chip enable stay stable around the strobe. A read is followed by a turnaround gap before the controller may drive the bus again. With no request pending, the memory is left in standby.

Top module: `sram_port_ctrl`

## Requirements
- R1: Out of reset, and whenever no request is in progress, chip enable, write enable and output enable are high (inactive), the data drive enable is 0 and the acknowledge is 0.
- R2: An accepted write (host_we = 1) runs three phases. First, chip enable is low with write enable high for ADDR_SETUP_CYC cycles. Then write enable is low for STROBE_CYC cycles. Then write enable is high with chip enable still low for HOLD_CYC cycles. The acknowledge appears ADDR_SETUP_CYC + STROBE_CYC + HOLD_CYC cycles after the accepting edge, and the byte is then stored at the requested address.
- R3: While write enable is low, and in the cycle it rises, the address and driven data are unchanged from the previous cycle and chip enable is low.
- R4: An accepted read (host_we = 0) holds chip enable and output enable low, with write enable high and drivers off, for ACCESS_CYC cycles. The bus is sampled on the last of those cycles. The acknowledge appears ACCESS_CYC cycles after the accepting edge, with that byte on host_rdata.
- R5: The acknowledge is high for exactly one cycle per request. host_rdata keeps the last read byte until the next read completes.
- R6: After output enable rises, the data drivers stay off for at least TURN_CYC + 1 full cycles.
- R7: The data drivers are never enabled while output enable is low, and write enable is never low while output enable is low.
- R8: Host address, data and flag are taken only on the accepting edge. Changes to them while a request is in progress have no effect on that access. A request still high in its acknowledge cycle is not taken a second time.
- R9: Whenever chip enable is high, write enable and output enable are high and the drivers are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request, held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Last read byte |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data value to drive onto the bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data seen on the bus |

## Verification
The bench memory model returns a junk byte during the first cycle of any read. A controller that samples one cycle early would therefore hand the host the junk value instead of the stored byte. Back-to-back read-then-write and write-then-read requests, issued in the very cycle of the previous acknowledge, probe two faults. One is a missing turnaround, which would show the drivers turning on right after output enable rises. The other is a double acceptance, which would show an extra acknowledge with nothing queued. Changing the host address and data in the middle of an access catches a design that reads them live: the byte would land at the wrong address or carry the wrong value. Phase-length counts around the write strobe catch setup, strobe or hold phases that are off by one.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WSTROBE,
        ST_WHOLD,
        ST_RACCESS,
        ST_RTURN
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       ce_n;
        logic       we_n;
        logic       oe_n;
        logic       dq_oe;
        logic       ack;
    } seq_regs_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_cmd_latch.sv
module sram_cmd_latch #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_wdata
);
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [DATA_W-1:0] wdata_d, wdata_q;

    always_comb begin
        addr_d  = capture ? in_addr  : addr_q;
        wdata_d = capture ? in_wdata : wdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
        end
    end

    assign out_addr  = addr_q;
    assign out_wdata = wdata_q;
endmodule

// File: rtl/sram_rdata_hold.sv
module sram_rdata_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = capture ? bus_in : data_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_out = data_q;
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W         = 15,
    parameter int DATA_W         = 8,
    parameter int ADDR_SETUP_CYC = 1,
    parameter int STROBE_CYC     = 1,
    parameter int HOLD_CYC       = 1,
    parameter int ACCESS_CYC     = 2,
    parameter int TURN_CYC       = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAX_CYC = max2(max2(max2(ADDR_SETUP_CYC, STROBE_CYC),
                                       max2(HOLD_CYC, ACCESS_CYC)), TURN_CYC);
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(ADDR_SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_STROBE = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN   = CNT_W'(TURN_CYC - 1);

    localparam seq_regs_t REGS_IDLE = '{
        state: ST_IDLE, ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0, ack: 1'b0
    };

    seq_regs_t        r_d, r_q;
    logic             accept;
    logic             rd_capture;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;

    // Next-state logic: every registered strobe is computed here.
    always_comb begin
        r_d        = r_q;
        r_d.ack    = 1'b0;
        accept     = 1'b0;
        rd_capture = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (host_req && !r_q.ack) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    r_d.ce_n = 1'b0;
                    if (host_we) begin
                        r_d.state = ST_WSETUP;
                        r_d.dq_oe = 1'b1;
                        tmr_val   = LD_SETUP;
                    end else begin
                        r_d.state = ST_RACCESS;
                        r_d.oe_n  = 1'b0;
                        tmr_val   = LD_ACCESS;
                    end
                end
            end
            ST_WSETUP: begin
                if (tmr_done) begin
                    r_d.state = ST_WSTROBE;
                    r_d.we_n  = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_STROBE;
                end
            end
            ST_WSTROBE: begin
                if (tmr_done) begin
                    r_d.state = ST_WHOLD;
                    r_d.we_n  = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_HOLD;
                end
            end
            ST_WHOLD: begin
                if (tmr_done) begin
                    r_d       = REGS_IDLE;
                    r_d.ack   = 1'b1;
                end
            end
            ST_RACCESS: begin
                if (tmr_done) begin
                    rd_capture = 1'b1;
                    r_d.state  = ST_RTURN;
                    r_d.ce_n   = 1'b1;
                    r_d.oe_n   = 1'b1;
                    r_d.ack    = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_TURN;
                end
            end
            ST_RTURN: begin
                if (tmr_done) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: begin
                r_d = REGS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= REGS_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    sram_cmd_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (accept),
        .in_addr   (host_addr),
        .in_wdata  (host_wdata),
        .out_addr  (mem_addr),
        .out_wdata (mem_dq_out)
    );

    sram_rdata_hold #(
        .DATA_W (DATA_W)
    ) u_rdata (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rd_capture),
        .bus_in   (mem_dq_in),
        .data_out (host_rdata)
    );

    assign mem_ce_n  = r_q.ce_n;
    assign mem_we_n  = r_q.we_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_dq_oe = r_q.dq_oe;
    assign host_ack  = r_q.ack;
endmodule

// File: rtl/sram_port_ctrl_chk.sv
module sram_port_ctrl_chk #(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 8,
    parameter int TURN_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic              host_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out
);
    localparam int RUN_W = $clog2(TURN_CYC + 2) + 1;

    // Cycles elapsed since output enable was last low (saturating).
    logic [RUN_W-1:0] oe_hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_hi_run <= '1;
        end else if (!mem_oe_n) begin
            oe_hi_run <= '0;
        end else if (oe_hi_run != '1) begin
            oe_hi_run <= oe_hi_run + 1'b1;
        end
    end

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

    p_we_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    p_strobe_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || $rose(mem_we_n)) |->
            ($stable(mem_addr) && $stable(mem_dq_out) && !mem_ce_n));

    p_read_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n));

    p_oe_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);

    p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (int'(oe_hi_run) >= TURN_CYC + 1));

    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
endmodule

bind sram_port_ctrl sram_port_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TURN_CYC (TURN_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_oe  (mem_dq_oe),
    .host_ack   (host_ack),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out)
);

// File: tb/sram_port_ctrl_bench.sv
module sram_port_ctrl_bench;
    localparam int AW = 15;
    localparam int DW = 8;
    localparam int S  = 1;
    localparam int W  = 1;
    localparam int H  = 1;
    localparam int RA = 2;
    localparam int T  = 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          host_req, host_we;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] host_wdata;
    logic          host_ack;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    sram_port_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .ADDR_SETUP_CYC(S), .STROBE_CYC(W),
        .HOLD_CYC(H), .ACCESS_CYC(RA), .TURN_CYC(T)
    ) u_sram_port_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // ---------------- memory model ----------------
    logic [DW-1:0] model_mem [int];
    logic [DW-1:0] ref_mem   [int];
    logic [3:0]    rd_age;
    logic          pend_valid;
    logic [AW-1:0] pend_a;
    logic [DW-1:0] pend_d;
    int            contention;
    logic          reading;

    function automatic logic [DW-1:0] model_rd(input int a);
        return model_mem.exists(a) ? model_mem[a] : '0;
    endfunction

    assign reading = !mem_ce_n && !mem_oe_n && mem_we_n;

    // First cycle of any read returns junk; valid data after one cycle.
    always_comb begin
        mem_dq_in = (reading && rd_age != 0) ? model_rd(int'(mem_addr)) : 8'hEE;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_age     <= '0;
            pend_valid <= 1'b0;
            contention <= 0;
        end else begin
            rd_age <= reading ? ((rd_age == 4'hF) ? rd_age : rd_age + 1'b1) : '0;
            if (mem_dq_oe && !mem_oe_n) contention <= contention + 1;
            if (!mem_we_n && !mem_ce_n) begin
                pend_valid <= 1'b1;
                pend_a     <= mem_addr;
                pend_d     <= mem_dq_out;
            end else if (pend_valid) begin
                if (!mem_ce_n) model_mem[int'(pend_a)] = pend_d;
                pend_valid <= 1'b0;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit            rd;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } item_t;
    item_t exp_q[$];

    int cyc, start_cyc, pre, wl, post, rdc, oe_hi;
    bit ce_prev, ack_prev, dqoe_prev, saw_we, seen_read;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc <= 0; ce_prev <= 1'b1; ack_prev <= 1'b0; dqoe_prev <= 1'b0;
            oe_hi <= 100; seen_read <= 1'b0;
        end else begin
            int p, w_, po, r_, st;
            bit sw;
            item_t it;
            p = pre; w_ = wl; po = post; r_ = rdc; st = start_cyc; sw = saw_we;
            cyc <= cyc + 1;
            if (ce_prev && !mem_ce_n) begin
                p = 0; w_ = 0; po = 0; r_ = 0; st = cyc; sw = 1'b0;
            end
            if (!mem_ce_n) begin
                if (!mem_oe_n) r_++;
                if (!mem_we_n) begin w_++; sw = 1'b1; end
                else if (sw) po++;
                else if (mem_oe_n) p++;
            end
            pre <= p; wl <= w_; post <= po; rdc <= r_; start_cyc <= st; saw_we <= sw;

            if (!mem_oe_n) begin
                oe_hi <= 0; seen_read <= 1'b1;
            end else if (oe_hi < 100) begin
                oe_hi <= oe_hi + 1;
            end
            // R6: drivers turn on only after TURN+1 quiet cycles
            if (mem_dq_oe && !dqoe_prev && seen_read)
                chk((oe_hi + (mem_oe_n ? 1 : 0) - 1) >= T + 1, "R6",
                    "quiet cycles before drive", oe_hi, T + 1);

            if (host_ack) begin
                chk(!ack_prev, "R5", "ack lasted more than one cycle", 1, 0);
                chk(exp_q.size() != 0, "R8", "ack with nothing pending",
                    exp_q.size(), 1);
                if (exp_q.size() != 0) begin
                    it = exp_q.pop_front();
                    if (it.rd) begin
                        chk(host_rdata == it.d, "R4", "read data", host_rdata, it.d);
                        chk(cyc - st == RA, "R4", "read latency", cyc - st, RA);
                        chk(r_ == RA, "R4", "oe low cycles", r_, RA);
                    end else begin
                        chk(model_rd(int'(it.a)) == it.d, "R2", "stored byte",
                            model_rd(int'(it.a)), it.d);
                        chk(cyc - st == S + W + H, "R2", "write latency",
                            cyc - st, S + W + H);
                        chk(p == S && w_ == W && po == H, "R2", "setup/strobe/hold",
                            p * 256 + w_ * 16 + po, S * 256 + W * 16 + H);
                    end
                end
            end
            ce_prev   <= mem_ce_n;
            ack_prev  <= host_ack;
            dqoe_prev <= mem_dq_oe;
        end
    end

    // ---------------- driver ----------------
    task automatic do_op(input bit rd, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input bit tight, input bit scramble);
        item_t it;
        it.rd = rd;
        it.a  = a;
        if (rd) it.d = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : '0;
        else begin
            it.d = d;
            ref_mem[int'(a)] = d;
        end
        exp_q.push_back(it);
        if (!tight) @(negedge clk);
        host_req   = 1'b1;
        host_we    = !rd;
        host_addr  = a;
        host_wdata = d;
        if (scramble) begin
            @(negedge clk);
            host_addr  = ~a;
            host_wdata = ~d;
            host_we    = rd;
        end
        do @(negedge clk); while (!host_ack);
        host_req = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        chk(mem_ce_n && mem_we_n && mem_oe_n, tag, "strobes idle",
            {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        chk(!mem_dq_oe && !host_ack, tag, "drive/ack idle",
            {mem_dq_oe, host_ack}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        logic [15:0]   lcg;
        rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0;
        host_addr = '0; host_wdata = '0;
        repeat (5) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // R8: idle wiggling of host inputs with no request does nothing
        for (int i = 0; i < 4; i++) begin
            host_addr = AW'(i * 33); host_wdata = DW'(i); host_we = i[0];
            @(negedge clk);
            check_idle("R8");
            chk(mem_ce_n, "R9", "standby holds", mem_ce_n, 1);
        end

        // R2: writes with distinct patterns including address extremes
        do_op(1'b0, 15'h0000, 8'h5A, 1'b0, 1'b0);
        do_op(1'b0, 15'h7FFF, 8'hC3, 1'b0, 1'b0);
        do_op(1'b0, 15'h1234, 8'h00, 1'b0, 1'b0);
        do_op(1'b0, 15'h4321, 8'hFF, 1'b0, 1'b0);
        // R4: read back, issued tight behind each ack
        do_op(1'b1, 15'h0000, 8'h00, 1'b1, 1'b0);
        do_op(1'b1, 15'h7FFF, 8'h00, 1'b1, 1'b0);
        do_op(1'b1, 15'h1234, 8'h00, 1'b1, 1'b0);
        do_op(1'b1, 15'h4321, 8'h00, 1'b1, 1'b0);

        // R5: read data held through idle and a following write
        held = host_rdata;
        repeat (3) @(negedge clk);
        chk(host_rdata == held, "R5", "rdata hold idle", host_rdata, held);
        do_op(1'b0, 15'h0100, 8'hA7, 1'b0, 1'b0);
        chk(host_rdata == held, "R5", "rdata hold across write", host_rdata, held);

        // R6: write then read, read then write, all tight
        do_op(1'b1, 15'h0100, 8'h00, 1'b1, 1'b0);
        do_op(1'b0, 15'h0200, 8'h3C, 1'b1, 1'b0);
        do_op(1'b1, 15'h0200, 8'h00, 1'b1, 1'b0);
        do_op(1'b0, 15'h0201, 8'h96, 1'b1, 1'b0);

        // R8: host inputs changed mid-access
        do_op(1'b0, 15'h0055, 8'h66, 1'b0, 1'b1);
        chk(!model_mem.exists(int'(~15'h0055)), "R8", "scrambled address untouched",
            model_mem.exists(int'(~15'h0055)), 0);
        do_op(1'b1, 15'h0055, 8'h00, 1'b0, 1'b1);

        // mixed traffic
        lcg = 16'hACE1;
        for (int i = 0; i < 24; i++) begin
            lcg = lcg * 16'd25173 + 16'd13849;
            do_op(lcg[15], {7'h08, lcg[7:0]}, lcg[14:7], lcg[3], 1'b0);
        end

        repeat (4) @(negedge clk);
        check_idle("R1");
        chk(exp_q.size() == 0, "R5", "every request acknowledged", exp_q.size(), 0);
        chk(contention == 0, "R7", "drive while output enabled", contention, 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule